// File: doc/BRIEF.md
# Address-Encoded NAND Command Sequencer

This block connects a simple 32-bit memory-mapped slave port to a raw 8-bit NAND flash bus. No control registers exist. Each access carries its instructions in the address itself. One address bit picks a command-phase access or a data-phase access. In command phase, address fields give the leading opcode, the number of address cycles and an optional trailing opcode, and the data word supplies the address bytes. In data phase, the data word is written to the flash as payload, or the flash payload is read back into the returned word. A final-chunk flag sits in the address as well.

Software drives a whole flash operation as a short series of bus accesses. A page program is an opcode write with five address bytes, which takes two writes to the same offset. Payload writes follow, and the final payload write also carries the confirm opcode. A page read is an opcode write whose trailing opcode is the read confirm, followed by payload reads. These reads wait for the ready/busy line. The chip enable stays asserted across the whole series. A one-clock pulse marks the end of a flagged final chunk, so an external error-correction engine can close its block.

Top module: `nseq_bridge`

## Requirements
- R1: After reset, CE# is high, WE# and RE# are high, CLE and ALE are low, the I/O bus is not driven, bus_ready is low and ecc_last is low.
- R2: Address bit 19 selects the phase. 0 means command phase and 1 means data phase.
- R3: A command-phase write first issues one CLE cycle carrying address bits 10:3. It then issues as many ALE cycles as address bits 23:21 give (0 to 7), with the address bytes taken from bus_wdata least-significant byte first.
- R4: When the cycle count exceeds 4, the write issues the opcode and 4 address bytes and then completes. The next command-phase write to the same address issues only the remaining count-4 ALE cycles, from the low bytes of its data word, with no opcode. A command-phase write to any other address instead starts a new command. A count of exactly 4 leaves nothing pending.
- R5: When address bit 20 is set, the byte in address bits 18:11 is issued as a CLE cycle. On a command-phase write this happens after the ALE cycles of its final part. On a data-phase write it happens after the four data bytes. On a data-phase read, bit 20 has no effect.
- R6: A data-phase write issues four WE# cycles with CLE and ALE low, carrying bus_wdata least-significant byte first.
- R7: A data-phase read issues four RE# cycles. The byte captured in the first cycle lands in bus_rdata bits 7:0 and the fourth lands in bits 31:24.
- R8: A data-phase read starts no RE# cycle while R/B# is low. It proceeds once R/B# is high.
- R9: ecc_last pulses for exactly one clock after the last byte of a data-phase access that has address bit 10 set. It does not pulse for any other access.
- R10: CE# goes low for the first NAND cycle of an access. It stays low across following accesses and returns high only when a data-phase access with address bit 10 set completes.
- R11: Each WE# or RE# pulse stays low for exactly T_LO clocks, and the line stays high for at least T_HI clocks between pulses. bus_ready stays low while any strobe is low, and is high for one clock at the end of each access.
- R12: A command-phase read is acknowledged with zero data. It issues no NAND cycle and leaves CE# unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_valid | input | 1 | Access request, held until bus_ready |
| bus_write | input | 1 | 1 for write, 0 for read |
| bus_addr | input | ADDR_W | Access offset carrying phase, opcodes, count and flags |
| bus_wdata | input | DATA_W | Write data: address bytes or payload |
| bus_ready | output | 1 | One-clock completion of the access |
| bus_rdata | output | DATA_W | Read data, valid with bus_ready |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_io_out | output | 8 | Byte driven onto the flash I/O bus |
| nand_io_oe | output | 1 | Output enable for nand_io_out |
| nand_io_in | input | 8 | Byte read from the flash I/O bus |
| nand_rb_n | input | 1 | Ready/busy from the flash, low while busy |
| ecc_last | output | 1 | One-clock end-of-final-chunk pulse |

## Verification
Two events fall in the same clock. One is the end of the last data byte slot. The other is the sequencer choosing its next item, which may be the end-of-chunk pulse or the trailing opcode cycle. The bench provokes this with final writes that set both the chunk flag and the trailing-opcode bit. It judges the result from the flash-side event order, the single-clock width of ecc_last, and the pulse count.

A second collision is a read that is held off by a low R/B#. The bench holds R/B# low while a read request waits. It confirms that no RE# pulse and no bus_ready appear, then releases R/B# and checks the gathered word.

// File: rtl/nseq_pkg.sv
package nseq_pkg;

    // bit positions in the access offset (the decoder and software agree on these)
    localparam int P_OP0_LO  = 3;
    localparam int P_ECC     = 10;
    localparam int P_OP1_LO  = 11;
    localparam int P_PHASE   = 19;
    localparam int P_OP1_V   = 20;
    localparam int P_CNT_LO  = 21;
    localparam int CNT_W     = 3;
    localparam int MIN_ADDR_W = P_CNT_LO + CNT_W;

    typedef enum logic [1:0] {K_CMD, K_ADR, K_WR, K_RD} cyc_kind_e;
    typedef enum logic [1:0] {S_IDLE, S_RUN, S_ACK} seq_st_e;

    typedef struct packed {
        logic             data_ph;
        logic [7:0]       op0;
        logic [7:0]       op1;
        logic             op1_v;
        logic [CNT_W-1:0] ncyc;
        logic             last;
    } acc_fields_t;

endpackage

// File: rtl/nseq_decode.sv
module nseq_decode
    import nseq_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  logic [ADDR_W-1:0] addr,
    output acc_fields_t       fld
);
    always_comb begin
        fld.data_ph = addr[P_PHASE];
        fld.op0     = addr[P_OP0_LO +: 8];
        fld.op1     = addr[P_OP1_LO +: 8];
        fld.op1_v   = addr[P_OP1_V];
        fld.ncyc    = addr[P_CNT_LO +: CNT_W];
        fld.last    = addr[P_ECC];
    end
endmodule

// File: rtl/nseq_rbsync.sv
module nseq_rbsync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rb_n_async,
    output logic rb_ok
);
    logic [STAGES-1:0] sync_d, sync_q;

    always_comb sync_d = {sync_q[STAGES-2:0], rb_n_async};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    assign rb_ok = sync_q[STAGES-1];
endmodule

// File: rtl/nseq_strobe.sv
module nseq_strobe
    import nseq_pkg::*;
#(
    parameter int T_LO = 2,
    parameter int T_HI = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go,
    input  cyc_kind_e  kind,
    input  logic [7:0] dbyte_in,
    input  logic [7:0] io_in,
    output logic       we_n,
    output logic       re_n,
    output logic       cle,
    output logic       ale,
    output logic [7:0] io_out,
    output logic       io_oe,
    output logic       done,
    output logic [7:0] rd_byte
);
    localparam int TMAX = (T_LO > T_HI) ? T_LO : T_HI;
    localparam int CW   = $clog2(TMAX + 1);

    typedef struct packed {
        logic          active;
        logic          lo;
        logic [CW-1:0] cnt;
        cyc_kind_e     kind;
        logic [7:0]    dbyte;
        logic [7:0]    rd;
    } stb_t;

    stb_t q, d;

    always_comb begin
        d    = q;
        done = 1'b0;
        if (!q.active) begin
            if (go) begin
                d.active = 1'b1;
                d.lo     = 1'b1;
                d.cnt    = '0;
                d.kind   = kind;
                d.dbyte  = dbyte_in;
            end
        end else if (q.lo) begin
            if (q.cnt == CW'(T_LO - 1)) begin
                d.lo  = 1'b0;
                d.cnt = '0;
                if (q.kind == K_RD) d.rd = io_in;
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end else begin
            if (q.cnt == CW'(T_HI - 1)) begin
                d.active = 1'b0;
                done     = 1'b1;
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign we_n    = !(q.active && q.lo && q.kind != K_RD);
    assign re_n    = !(q.active && q.lo && q.kind == K_RD);
    assign cle     = q.active && q.kind == K_CMD;
    assign ale     = q.active && q.kind == K_ADR;
    assign io_oe   = q.active && q.kind != K_RD;
    assign io_out  = q.dbyte;
    assign rd_byte = q.rd;

    AST_IO_HELD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!we_n && $past(!we_n)) |-> $stable(io_out)); // R11
endmodule

// File: rtl/nseq_bridge.sv
module nseq_bridge
    import nseq_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 32,
    parameter int T_LO   = 2,
    parameter int T_HI   = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic              bus_ready,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              nand_ce_n,
    output logic              nand_cle,
    output logic              nand_ale,
    output logic              nand_we_n,
    output logic              nand_re_n,
    output logic [7:0]        nand_io_out,
    output logic              nand_io_oe,
    input  logic [7:0]        nand_io_in,
    input  logic              nand_rb_n,
    output logic              ecc_last
);
    localparam int BPW = DATA_W / 8;
    localparam int DLW = $clog2(BPW + 1);

    typedef struct packed {
        seq_st_e          st;
        logic             ce_n;
        logic             cmd0_todo;
        logic [7:0]       op0;
        logic [CNT_W-1:0] adr_left;
        logic [DLW-1:0]   dat_left;
        logic             rd;
        logic             ecc_todo;
        logic             last_flag;
        logic             cmd1_todo;
        logic [7:0]       op1;
        logic [DATA_W-1:0] word;
        logic [DATA_W-1:0] rdata;
        logic             ecc_pulse;
        logic             split_pend;
        logic [CNT_W-1:0] split_left;
        logic [ADDR_W-1:0] split_off;
    } seq_t;

    seq_t        q, d;
    acc_fields_t fld;
    logic        rb_ok;
    logic        sq_go;
    cyc_kind_e   sq_kind;
    logic [7:0]  sq_byte;
    logic        stb_done;
    logic [7:0]  stb_rd;

    nseq_decode #(.ADDR_W(ADDR_W)) u_dec (.addr(bus_addr), .fld(fld));

    nseq_rbsync #(.STAGES(2)) u_rb (
        .clk(clk), .rst_n(rst_n), .rb_n_async(nand_rb_n), .rb_ok(rb_ok)
    );

    always_comb begin
        d           = q;
        d.ecc_pulse = 1'b0;
        sq_go       = 1'b0;
        sq_kind     = K_CMD;
        sq_byte     = '0;
        unique case (q.st)
            S_IDLE: if (bus_valid) begin
                d.st        = S_RUN;
                d.word      = bus_wdata;
                d.rdata     = '0;
                d.last_flag = 1'b0;
                d.ecc_todo  = 1'b0;
                d.dat_left  = '0;
                d.cmd0_todo = 1'b0;
                d.adr_left  = '0;
                d.op1       = fld.op1;
                d.op0       = fld.op0;
                if (!fld.data_ph) begin
                    if (!bus_write) begin
                        d.st        = S_ACK;          // no flash cycle at all
                        d.cmd1_todo = 1'b0;
                    end else if (q.split_pend && bus_addr == q.split_off) begin
                        d.ce_n       = 1'b0;
                        d.adr_left   = q.split_left;
                        d.cmd1_todo  = fld.op1_v;
                        d.split_pend = 1'b0;
                    end else begin
                        d.ce_n      = 1'b0;
                        d.cmd0_todo = 1'b1;
                        if (fld.ncyc > CNT_W'(BPW)) begin
                            d.adr_left   = CNT_W'(BPW);
                            d.split_pend = 1'b1;
                            d.split_left = fld.ncyc - CNT_W'(BPW);
                            d.split_off  = bus_addr;
                            d.cmd1_todo  = 1'b0;
                        end else begin
                            d.adr_left   = fld.ncyc;
                            d.split_pend = 1'b0;
                            d.cmd1_todo  = fld.op1_v;
                        end
                    end
                end else begin
                    d.ce_n       = 1'b0;
                    d.split_pend = 1'b0;
                    d.dat_left   = DLW'(BPW);
                    d.rd         = !bus_write;
                    d.ecc_todo   = fld.last;
                    d.last_flag  = fld.last;
                    d.cmd1_todo  = bus_write && fld.op1_v;
                end
            end
            S_RUN: begin
                if (q.cmd0_todo) begin
                    sq_go   = 1'b1;
                    sq_kind = K_CMD;
                    sq_byte = q.op0;
                    if (stb_done) d.cmd0_todo = 1'b0;
                end else if (q.adr_left != '0) begin
                    sq_go   = 1'b1;
                    sq_kind = K_ADR;
                    sq_byte = q.word[7:0];
                    if (stb_done) begin
                        d.adr_left = q.adr_left - 1'b1;
                        d.word     = q.word >> 8;
                    end
                end else if (q.dat_left != '0) begin
                    sq_kind = q.rd ? K_RD : K_WR;
                    sq_byte = q.word[7:0];
                    sq_go   = !q.rd || rb_ok;
                    if (stb_done) begin
                        d.dat_left = q.dat_left - 1'b1;
                        d.word     = q.word >> 8;
                        if (q.rd) d.rdata = {stb_rd, q.rdata[DATA_W-1:8]};
                    end
                end else if (q.ecc_todo) begin
                    d.ecc_todo  = 1'b0;
                    d.ecc_pulse = 1'b1;
                end else if (q.cmd1_todo) begin
                    sq_go   = 1'b1;
                    sq_kind = K_CMD;
                    sq_byte = q.op1;
                    if (stb_done) d.cmd1_todo = 1'b0;
                end else begin
                    d.st = S_ACK;
                end
            end
            default: begin
                d.st = S_IDLE;
                if (q.last_flag) d.ce_n = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.ce_n <= 1'b1;
        end else begin
            q <= d;
        end
    end

    nseq_strobe #(.T_LO(T_LO), .T_HI(T_HI)) u_stb (
        .clk(clk), .rst_n(rst_n), .go(sq_go), .kind(sq_kind), .dbyte_in(sq_byte),
        .io_in(nand_io_in), .we_n(nand_we_n), .re_n(nand_re_n), .cle(nand_cle),
        .ale(nand_ale), .io_out(nand_io_out), .io_oe(nand_io_oe), .done(stb_done),
        .rd_byte(stb_rd)
    );

    assign bus_ready = q.st == S_ACK;
    assign bus_rdata = q.rdata;
    assign nand_ce_n = q.ce_n;
    assign ecc_last  = q.ecc_pulse;

    AST_READY_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ready |-> (nand_we_n && nand_re_n)); // R11
    AST_CE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!nand_we_n || !nand_re_n) |-> !nand_ce_n); // R10
    AST_READ_WAITS_RB: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(nand_re_n) |-> $past(rb_ok)); // R8
    AST_ECC_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        ecc_last |=> !ecc_last); // R9
    AST_ECC_QUIET_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        ecc_last |-> (nand_we_n && nand_re_n && !bus_ready)); // R9
endmodule

// File: tb/sim_nseq_bridge.sv
`timescale 1ns/1ps
module sim_nseq_bridge;
    localparam int TLO = 2;
    localparam int THI = 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [23:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_ready;
    logic [31:0] bus_rdata;
    logic        nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_io_oe;
    logic [7:0]  nand_io_out;
    logic [7:0]  nand_io_in = 8'h00;
    logic        nand_rb_n = 1'b1;
    logic        ecc_last;

    int n_cmp = 0;
    int n_bad = 0;
    int exp_q[$];
    int ecc_seen = 0;
    int ecc_exp  = 0;
    int ev_count = 0;
    int re_falls = 0;
    logic [7:0] rd_pat = 8'h40;
    bit running = 1'b0;

    always #2 clk = ~clk;

    nseq_bridge #(.ADDR_W(24), .DATA_W(32), .T_LO(TLO), .T_HI(THI)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ready(bus_ready),
        .bus_rdata(bus_rdata), .nand_ce_n(nand_ce_n), .nand_cle(nand_cle),
        .nand_ale(nand_ale), .nand_we_n(nand_we_n), .nand_re_n(nand_re_n),
        .nand_io_out(nand_io_out), .nand_io_oe(nand_io_oe), .nand_io_in(nand_io_in),
        .nand_rb_n(nand_rb_n), .ecc_last(ecc_last)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [23:0] cmd_a(input int op0, input int n, input int op1, input int v);
        return 24'((n << 21) | (v << 20) | (op1 << 11) | (op0 << 3));
    endfunction

    function automatic logic [23:0] dat_a(input int last, input int op1, input int v);
        return 24'((1 << 19) | (v << 20) | (op1 << 11) | (last << 10));
    endfunction

    // event codes: 0 data write, 1 opcode, 2 address, 3 data read (byte ignored)
    task automatic push(input int k, input int b);
        exp_q.push_back(k * 256 + (b & 255));
    endtask

    // flash model: present a new byte on every read strobe
    always @(negedge nand_re_n) begin
        nand_io_in = rd_pat;
        rd_pat     = rd_pat + 8'd1;
    end

    // per-clock monitor
    bit prev_lo = 1'b0, ecc_prev = 1'b0, cap_re = 1'b0, cap_cle = 1'b0, cap_ale = 1'b0, cap_oe = 1'b0;
    logic [7:0] cap_io = '0;
    int lo_cnt = 0, hi_cnt = 99;
    always @(negedge clk) if (running) begin
        bit lo_now;
        lo_now = !nand_we_n || !nand_re_n;
        chk(!(lo_now && (nand_ce_n || bus_ready)), "R10/R11 strobe with CE high or ready",
            {nand_ce_n, bus_ready}, 0);
        chk(!(ecc_last && ecc_prev), "R9 ecc_last wider than one clock", 1, 0);
        if (ecc_last) ecc_seen++;
        ecc_prev = ecc_last;
        if (lo_now) begin
            if (!prev_lo) begin
                chk(hi_cnt >= THI, "R11 strobe high width", hi_cnt, THI);
                lo_cnt = 0;
                if (!nand_re_n) re_falls++;
            end
            lo_cnt++;
            cap_re = !nand_re_n; cap_cle = nand_cle; cap_ale = nand_ale;
            cap_io = nand_io_out; cap_oe = nand_io_oe;
            hi_cnt = 0;
        end else begin
            hi_cnt++;
            if (prev_lo) begin
                int k;
                int e;
                ev_count++;
                chk(lo_cnt == TLO, "R11 strobe low width", lo_cnt, TLO);
                k = cap_re ? 3 : (cap_cle ? 1 : (cap_ale ? 2 : 0));
                if (exp_q.size() == 0) begin
                    chk(0, "R3 unexpected flash cycle", k * 256 + cap_io, -1);
                end else begin
                    e = exp_q.pop_front();
                    chk(k == e / 256, "R3/R5/R6/R7 cycle kind", k, e / 256);
                    if (k != 3) chk(cap_io == 8'(e), "R3/R4/R6 cycle byte", cap_io, e & 255);
                    chk(cap_oe == (k != 3), "R6/R7 bus direction", cap_oe, k != 3);
                end
            end
        end
        prev_lo = lo_now;
    end

    task automatic xfer(input bit wr, input logic [23:0] a, input logic [31:0] dw,
                        output logic [31:0] r);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = wr; bus_addr = a; bus_wdata = dw;
        do @(negedge clk); while (!bus_ready);
        r = bus_rdata;
        bus_valid = 1'b0;
    endtask

    task automatic done_chk(input string tag, input bit ce_exp);
        @(negedge clk);
        chk(exp_q.size() == 0, {tag, " pending cycles"}, exp_q.size(), 0);
        chk(ecc_seen == ecc_exp, "R9 ecc_last count", ecc_seen, ecc_exp);
        chk(nand_ce_n == ce_exp, "R10 CE# level", nand_ce_n, ce_exp);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        chk(0, "watchdog expired", 0, 1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] r;
        logic [7:0]  p;
        int ev0;
        repeat (3) @(negedge clk);
        // R1 reset values
        chk(nand_ce_n && nand_we_n && nand_re_n && !nand_cle && !nand_ale && !nand_io_oe
            && !bus_ready && !ecc_last, "R1 reset state",
            {nand_ce_n, nand_we_n, nand_re_n, nand_cle, nand_ale, nand_io_oe, bus_ready, ecc_last},
            8'b1110_0000);
        rst_n = 1'b1;
        running = 1'b1;
        repeat (4) @(negedge clk);

        // R2 R3 R4: five address bytes split over two writes
        push(1, 8'h80); push(2, 8'h11); push(2, 8'h22); push(2, 8'h33); push(2, 8'h44);
        xfer(1'b1, cmd_a(8'h80, 5, 0, 0), 32'h44332211, r);
        done_chk("R3 first part", 1'b0);
        push(2, 8'h55);
        xfer(1'b1, cmd_a(8'h80, 5, 0, 0), 32'hAABBCC55, r);
        done_chk("R4 second part", 1'b0);

        // R6 payload, R5 R9 R10 final write with confirm
        push(0, 1); push(0, 2); push(0, 3); push(0, 4);
        xfer(1'b1, dat_a(0, 0, 0), 32'h04030201, r);
        done_chk("R6 payload", 1'b0);
        push(0, 5); push(0, 6); push(0, 7); push(0, 8); push(1, 8'h10);
        ecc_exp++;
        xfer(1'b1, dat_a(1, 8'h10, 1), 32'h08070605, r);
        done_chk("R5 final write confirm", 1'b1);

        // R5 command with trailing opcode
        push(1, 8'h00); push(2, 8'hAA); push(2, 8'hBB); push(2, 8'hCC); push(1, 8'h30);
        xfer(1'b1, cmd_a(8'h00, 3, 8'h30, 1), 32'hEECCBBAA, r);
        done_chk("R5 command confirm", 1'b0);

        // R8 read held off by busy, then R7 data gathering
        nand_rb_n = 1'b0;
        repeat (3) @(negedge clk);
        p = rd_pat;
        ev0 = re_falls;
        push(3, 0); push(3, 0); push(3, 0); push(3, 0);
        fork
            xfer(1'b0, dat_a(0, 0, 0), 32'h0, r);
            begin
                repeat (25) @(negedge clk);
                chk(re_falls == ev0, "R8 no read strobe while busy", re_falls, ev0);
                chk(bus_ready == 1'b0, "R8 access still pending", bus_ready, 0);
                nand_rb_n = 1'b1;
            end
        join
        chk(r == {p + 8'd3, p + 8'd2, p + 8'd1, p}, "R7 read word", r,
            {p + 8'd3, p + 8'd2, p + 8'd1, p});
        done_chk("R7 read", 1'b0);

        // R5 opcode bit ignored on reads, R9 R10 flagged read
        p = rd_pat;
        push(3, 0); push(3, 0); push(3, 0); push(3, 0);
        ecc_exp++;
        xfer(1'b0, dat_a(1, 8'h55, 1), 32'h0, r);
        chk(r == {p + 8'd3, p + 8'd2, p + 8'd1, p}, "R7 flagged read word", r,
            {p + 8'd3, p + 8'd2, p + 8'd1, p});
        done_chk("R5 read ignores opcode", 1'b1);

        // R12 command-phase read
        ev0 = ev_count;
        xfer(1'b0, cmd_a(8'h70, 2, 0, 0), 32'h0, r);
        chk(r == 0, "R12 command read data", r, 0);
        done_chk("R12 command read", 1'b1);
        chk(ev_count == ev0, "R12 no flash cycle", ev_count, ev0);

        // R4 pending split abandoned by another offset, then restarted
        push(1, 8'h60); push(2, 1); push(2, 2); push(2, 3); push(2, 4);
        xfer(1'b1, cmd_a(8'h60, 6, 0, 0), 32'h04030201, r);
        push(1, 8'h61); push(2, 8'h21); push(2, 8'h22);
        xfer(1'b1, cmd_a(8'h61, 2, 0, 0), 32'h00002221, r);
        done_chk("R4 other offset starts new command", 1'b0);
        push(1, 8'h60); push(2, 5); push(2, 6); push(2, 7); push(2, 8);
        xfer(1'b1, cmd_a(8'h60, 6, 0, 0), 32'h08070605, r);
        push(2, 9); push(2, 10);
        xfer(1'b1, cmd_a(8'h60, 6, 0, 0), 32'hFFFF0A09, r);
        done_chk("R4 restarted split", 1'b0);

        // R3 zero count, R4 exactly four leaves nothing pending
        push(1, 8'hFF);
        xfer(1'b1, cmd_a(8'hFF, 0, 0, 0), 32'h12345678, r);
        done_chk("R3 zero count", 1'b0);
        push(1, 8'h90); push(2, 8'hA1); push(2, 8'hA2); push(2, 8'hA3); push(2, 8'hA4);
        xfer(1'b1, cmd_a(8'h90, 4, 0, 0), 32'hA4A3A2A1, r);
        push(1, 8'h90); push(2, 8'hB1); push(2, 8'hB2); push(2, 8'hB3); push(2, 8'hB4);
        xfer(1'b1, cmd_a(8'h90, 4, 0, 0), 32'hB4B3B2B1, r);
        done_chk("R4 exact four", 1'b0);

        // R5 trailing opcode on unflagged write, R10 CE stays low until flagged access
        push(0, 8'hC1); push(0, 8'hC2); push(0, 8'hC3); push(0, 8'hC4); push(1, 8'h85);
        xfer(1'b1, dat_a(0, 8'h85, 1), 32'hC4C3C2C1, r);
        done_chk("R5 unflagged write opcode", 1'b0);
        push(0, 8'hD1); push(0, 8'hD2); push(0, 8'hD3); push(0, 8'hD4);
        ecc_exp++;
        xfer(1'b1, dat_a(1, 0, 0), 32'hD4D3D2D1, r);
        done_chk("R10 flagged write closes", 1'b1);

        repeat (5) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule